// File: doc/BRIEF.md
# Native Slot Clock with Sub-Slot Phase

This block keeps link timing for a short-range radio baseband. A divider turns the fast reference clock into a 4 MHz tick. A sub-slot phase counter runs on that tick and wraps once per half slot of 312.5 µs. Each wrap advances a free-running 28-bit native clock. A second, master-aligned time is formed by adding a programmable slot offset and phase offset to the native time. Firmware uses this second time to follow a remote master's timing.

Half-slot and slot boundary strobes are taken from the aligned time, so they mark the instants at which packets are sent or received. Two compare timers, one for transmit and one for receive, hold a target slot value and phase. Each fires a single-cycle task trigger when the aligned time reaches its target, and then stays idle until it is loaded again.

A low-power mode stops the phase counter and its divider. In that mode the native clock advances from an external slow enable, so it keeps counting without the fast tick.

Top module: `slot_timebase`

## Requirements
- R1: After a synchronous active-high reset, native time, aligned time, both offsets, both strobes and both task triggers are zero, and both timers are idle.
- R2: With `prescale_en` low, `native_ph` advances by one every DIV (default 4) cycles of `clk`; counting from the first edge that samples reset low, it first changes on the fourth edge.
- R3: `native_ph` counts 0 to PH_WRAP-1 (default 1249), then returns to 0, and `native_clk` advances by one at that same edge; `native_clk` wraps modulo 2^28.
- R4: A cycle with `ofs_wr` high loads both offsets at that edge. From the next cycle on, `master_ph` is `native_ph` plus the phase offset, less PH_WRAP if the sum is PH_WRAP or more. `master_clk` is `native_clk` plus the slot offset plus that carry, modulo 2^28.
- R5: A phase offset written with a value of PH_WRAP or more is stored as PH_WRAP-1.
- R6: `half_slot_stb` is high for the one cycle in which bit 0 of `master_clk` differs from its value in the previous cycle. `slot_stb` is high only in such a cycle where that bit has gone from 1 to 0.
- R7: A cycle with `task_arm` bit 0 (transmit) or bit 1 (receive) high loads `task_clk` and `task_ph` as that timer's target and arms it. `task_fire` with the same bit position goes high for one cycle, in the cycle after the first cycle in which the aligned time equals the target.
- R8: A timer disarms when it fires and does not fire again until it is reloaded. Reloading an armed timer replaces its target, so the earlier target never fires.
- R9: With `prescale_en` high, `native_ph` and the divider hold their values. `native_clk` then advances by one at each edge that samples `ext_tick` high, and otherwise holds.
- R10: When `prescale_en` returns low, the phase count resumes from its held value and the divider resumes from its held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| prescale_en | input | 1 | Low-power mode: phase held, native clock driven by `ext_tick` |
| ext_tick | input | 1 | Half-slot enable from a slow clock, used in low-power mode |
| ofs_wr | input | 1 | Load strobe for both offsets |
| ofs_clk | input | 28 | Slot offset added to the native clock |
| ofs_ph | input | 16 | Phase offset added to the native phase |
| task_arm | input | NUM_TASKS | Load-and-arm strobes, bit 0 transmit, bit 1 receive |
| task_clk | input | 28 | Target slot value for the timer being loaded |
| task_ph | input | 16 | Target phase for the timer being loaded |
| native_clk | output | 28 | Free-running half-slot count |
| native_ph | output | 16 | Position within the current half slot |
| master_clk | output | 28 | Offset-aligned half-slot count |
| master_ph | output | 16 | Offset-aligned phase |
| half_slot_stb | output | 1 | Half-slot boundary strobe |
| slot_stb | output | 1 | Full-slot boundary strobe |
| task_fire | output | NUM_TASKS | One-cycle task triggers, bit 0 transmit, bit 1 receive |

## Verification
The hardest cases to reach from the ports are the phase carry into the slot value and the wrap of the aligned time through 2^28. At 5000 cycles per half slot, the native clock can never get near either one in a run. The stimulus first lets the counter run to a known native time, then freezes it with the low-power mode and no external enables. It then walks a table of offsets chosen to land exactly on the carry boundary, on either side of it, and across the 2^28 wrap, checking the aligned time after each write. Timer reload, disarm after firing and firing while in low-power mode are each driven at cycles computed from the divide ratio.

// File: rtl/stc_pkg.sv
package stc_pkg;

    localparam int unsigned STC_CLK_W = 28;
    localparam int unsigned STC_PH_W  = 16;

    typedef logic [STC_CLK_W-1:0] stc_clk_t;
    typedef logic [STC_PH_W-1:0]  stc_ph_t;

    // A point in link time: half-slot count plus position inside it.
    typedef struct packed {
        stc_clk_t slot;
        stc_ph_t  ph;
    } stc_time_t;

    // Add two times; the phase field is modulo wrap and carries into slot.
    function automatic stc_time_t stc_add(stc_time_t a, stc_time_t b, stc_ph_t wrap);
        logic [STC_PH_W:0] sum;
        logic              carry;
        stc_time_t         r;
        sum   = {1'b0, a.ph} + {1'b0, b.ph};
        carry = (sum >= {1'b0, wrap});
        r.ph  = carry ? stc_ph_t'(sum - {1'b0, wrap}) : sum[STC_PH_W-1:0];
        r.slot = a.slot + b.slot + {{(STC_CLK_W-1){1'b0}}, carry};
        return r;
    endfunction

    // Clamp a phase value into the legal range 0..wrap-1.
    function automatic stc_ph_t stc_sat_ph(stc_ph_t p, stc_ph_t wrap);
        return (p >= wrap) ? stc_ph_t'(wrap - 1'b1) : p;
    endfunction

endpackage

// File: rtl/stc_tick_div.sv
module stc_tick_div #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!hold) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = !hold && (cnt == LAST);
endmodule

// File: rtl/stc_native_ctr.sv
module stc_native_ctr
    import stc_pkg::*;
#(
    parameter int unsigned PH_WRAP = 1250
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      prescale,
    input  logic      ext_tick,
    output stc_time_t nat
);
    localparam stc_ph_t PH_LAST = stc_ph_t'(PH_WRAP - 1);

    stc_time_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (prescale) begin
            // phase frozen, slot count driven by the slow enable
            if (ext_tick) begin
                cur.slot <= cur.slot + 1'b1;
            end
        end else if (tick) begin
            if (cur.ph == PH_LAST) begin
                cur.ph   <= '0;
                cur.slot <= cur.slot + 1'b1;
            end else begin
                cur.ph <= cur.ph + 1'b1;
            end
        end
    end

    assign nat = cur;
endmodule

// File: rtl/stc_master_align.sv
module stc_master_align
    import stc_pkg::*;
#(
    parameter int unsigned PH_WRAP = 1250
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ofs_wr,
    input  stc_time_t ofs_in,
    input  stc_time_t nat,
    output stc_time_t mst,
    output logic      half_stb,
    output logic      slot_stb
);
    localparam stc_ph_t WRAP_V = stc_ph_t'(PH_WRAP);

    stc_time_t ofs_q;
    logic      lsb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
        end else if (ofs_wr) begin
            ofs_q.slot <= ofs_in.slot;
            ofs_q.ph   <= stc_sat_ph(ofs_in.ph, WRAP_V);
        end
    end

    assign mst = stc_add(nat, ofs_q, WRAP_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            lsb_q <= 1'b0;
        end else begin
            lsb_q <= mst.slot[0];
        end
    end

    assign half_stb = lsb_q ^ mst.slot[0];
    assign slot_stb = lsb_q & ~mst.slot[0];
endmodule

// File: rtl/stc_task_timer.sv
module stc_task_timer
    import stc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,
    input  stc_time_t tgt,
    input  stc_time_t mst,
    output logic      fire
);
    stc_time_t tgt_q;
    logic      armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
            armed <= 1'b0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (arm) begin
                tgt_q <= tgt;
                armed <= 1'b1;
            end else if (armed && (mst == tgt_q)) begin
                armed <= 1'b0;
                fire  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/slot_timebase.sv
module slot_timebase
    import stc_pkg::*;
#(
    parameter int unsigned DIV       = 4,
    parameter int unsigned PH_WRAP   = 1250,
    parameter int unsigned NUM_TASKS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prescale_en,
    input  logic                 ext_tick,
    input  logic                 ofs_wr,
    input  logic [27:0]          ofs_clk,
    input  logic [15:0]          ofs_ph,
    input  logic [NUM_TASKS-1:0] task_arm,
    input  logic [27:0]          task_clk,
    input  logic [15:0]          task_ph,
    output logic [27:0]          native_clk,
    output logic [15:0]          native_ph,
    output logic [27:0]          master_clk,
    output logic [15:0]          master_ph,
    output logic                 half_slot_stb,
    output logic                 slot_stb,
    output logic [NUM_TASKS-1:0] task_fire
);
    logic      tick;
    stc_time_t nat;
    stc_time_t mst;
    stc_time_t ofs_in;
    stc_time_t tgt_in;

    assign ofs_in.slot = ofs_clk;
    assign ofs_in.ph   = ofs_ph;
    assign tgt_in.slot = task_clk;
    assign tgt_in.ph   = task_ph;

    stc_tick_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .hold (prescale_en),
        .tick (tick)
    );

    stc_native_ctr #(.PH_WRAP(PH_WRAP)) u_nat (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .prescale (prescale_en),
        .ext_tick (ext_tick),
        .nat      (nat)
    );

    stc_master_align #(.PH_WRAP(PH_WRAP)) u_mst (
        .clk      (clk),
        .rst      (rst),
        .ofs_wr   (ofs_wr),
        .ofs_in   (ofs_in),
        .nat      (nat),
        .mst      (mst),
        .half_stb (half_slot_stb),
        .slot_stb (slot_stb)
    );

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_task
        stc_task_timer u_tmr (
            .clk  (clk),
            .rst  (rst),
            .arm  (task_arm[g]),
            .tgt  (tgt_in),
            .mst  (mst),
            .fire (task_fire[g])
        );
    end

    assign native_clk = nat.slot;
    assign native_ph  = nat.ph;
    assign master_clk = mst.slot;
    assign master_ph  = mst.ph;
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
    parameter int unsigned PH_WRAP   = 1250,
    parameter int unsigned NUM_TASKS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 prescale_en,
    input logic                 ext_tick,
    input logic [27:0]          native_clk,
    input logic [15:0]          native_ph,
    input logic [15:0]          master_ph,
    input logic                 half_slot_stb,
    input logic                 slot_stb,
    input logic [NUM_TASKS-1:0] task_fire
);
    localparam logic [15:0] WRAP_V = 16'(PH_WRAP);

    p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
        native_ph < WRAP_V);

    p_native_step_r3: assert property (@(posedge clk) disable iff (rst)
        (native_clk != $past(native_clk)) |-> (native_clk == 28'($past(native_clk) + 28'd1)));

    p_master_ph_bound_r4: assert property (@(posedge clk) disable iff (rst)
        master_ph < WRAP_V);

    p_slot_in_half_r6: assert property (@(posedge clk) disable iff (rst)
        slot_stb |-> half_slot_stb);

    p_prescale_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (prescale_en && !ext_tick) |=> ($stable(native_clk) && $stable(native_ph)));

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_fire
        p_fire_single_r8: assert property (@(posedge clk) disable iff (rst)
            task_fire[g] |=> !task_fire[g]);
    end
endmodule

bind slot_timebase stc_checker #(
    .PH_WRAP   (PH_WRAP),
    .NUM_TASKS (NUM_TASKS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .prescale_en   (prescale_en),
    .ext_tick      (ext_tick),
    .native_clk    (native_clk),
    .native_ph     (native_ph),
    .master_ph     (master_ph),
    .half_slot_stb (half_slot_stb),
    .slot_stb      (slot_stb),
    .task_fire     (task_fire)
);

// File: tb/tb_slot_timebase.sv
module tb_slot_timebase;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prescale_en = 1'b0;
    logic        ext_tick = 1'b0;
    logic        ofs_wr = 1'b0;
    logic [27:0] ofs_clk = '0;
    logic [15:0] ofs_ph = '0;
    logic [1:0]  task_arm = '0;
    logic [27:0] task_clk = '0;
    logic [15:0] task_ph = '0;
    logic [27:0] native_clk, master_clk;
    logic [15:0] native_ph, master_ph;
    logic        half_slot_stb, slot_stb;
    logic [1:0]  task_fire;

    int tests = 0;
    int fails = 0;
    int k = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) k <= 0;
        else     k <= k + 1;
    end

    slot_timebase dut (
        .clk           (clk),
        .rst           (rst),
        .prescale_en   (prescale_en),
        .ext_tick      (ext_tick),
        .ofs_wr        (ofs_wr),
        .ofs_clk       (ofs_clk),
        .ofs_ph        (ofs_ph),
        .task_arm      (task_arm),
        .task_clk      (task_clk),
        .task_ph       (task_ph),
        .native_clk    (native_clk),
        .native_ph     (native_ph),
        .master_clk    (master_clk),
        .master_ph     (master_ph),
        .half_slot_stb (half_slot_stb),
        .slot_stb      (slot_stb),
        .task_fire     (task_fire)
    );

    // Offset vectors applied with the native time frozen at slot 2, phase 500.
    // Fields: ofs_clk, ofs_ph, expected master_clk, expected master_ph.
    localparam int NV = 9;
    localparam logic [87:0] VEC [NV] = '{
        {28'h0000000, 16'd0,    28'h0000002, 16'd500},
        {28'h0000005, 16'd100,  28'h0000007, 16'd600},
        {28'h0000000, 16'd749,  28'h0000002, 16'd1249},
        {28'h0000000, 16'd750,  28'h0000003, 16'd0},
        {28'h000000A, 16'd1249, 28'h000000D, 16'd499},
        {28'hFFFFFFF, 16'd0,    28'h0000001, 16'd500},
        {28'hFFFFFFD, 16'd750,  28'h0000000, 16'd0},
        {28'h0000000, 16'd4000, 28'h0000003, 16'd499},
        {28'h0ABCDEF, 16'd0,    28'h0ABCDF1, 16'd500}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at k=%0d: actual %0h expected %0h", req, k, act, exp);
        end
    endtask

    task automatic run_to(input int target);
        while (k < target) @(negedge clk);
    endtask

    task automatic arm_timer(input int idx, input logic [27:0] c, input logic [15:0] p);
        task_arm = 2'b00;
        task_arm[idx] = 1'b1;
        task_clk = c;
        task_ph  = p;
        @(negedge clk);
        task_arm = 2'b00;
    endtask

    task automatic write_ofs(input logic [27:0] c, input logic [15:0] p);
        ofs_clk = c;
        ofs_ph  = p;
        ofs_wr  = 1'b1;
        @(negedge clk);
        ofs_wr  = 1'b0;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 native_clk", 64'(native_clk), 64'd0);
        check("R1 native_ph", 64'(native_ph), 64'd0);
        check("R1 master", 64'({master_clk, master_ph}), 64'd0);
        check("R1 strobes", 64'({half_slot_stb, slot_stb}), 64'd0);
        check("R1 task_fire", 64'(task_fire), 64'd0);

        // R2 divide by four
        run_to(3);  check("R2 ph before first tick", 64'(native_ph), 64'd0);
        run_to(4);  check("R2 first tick", 64'(native_ph), 64'd1);
        run_to(8);  check("R2 second tick", 64'(native_ph), 64'd2);

        // R3 wrap and native advance, R6 strobes
        run_to(4999);
        check("R3 last phase", 64'(native_ph), 64'd1249);
        check("R3 native before wrap", 64'(native_clk), 64'd0);
        check("R6 no strobe before edge", 64'(half_slot_stb), 64'd0);
        run_to(5000);
        check("R3 phase wraps", 64'(native_ph), 64'd0);
        check("R3 native advances", 64'(native_clk), 64'd1);
        check("R6 half strobe 0->1", 64'(half_slot_stb), 64'd1);
        check("R6 no slot strobe 0->1", 64'(slot_stb), 64'd0);
        run_to(5001);
        check("R6 half strobe one cycle", 64'(half_slot_stb), 64'd0);
        run_to(10000);
        check("R6 half strobe 1->0", 64'(half_slot_stb), 64'd1);
        check("R6 slot strobe 1->0", 64'(slot_stb), 64'd1);
        run_to(10001);
        check("R6 slot strobe one cycle", 64'(slot_stb), 64'd0);

        // R7/R8 timers: TX at (2,10) replaced by (2,20), RX at (2,12)
        run_to(10005); arm_timer(0, 28'd2, 16'd10);
        run_to(10010); arm_timer(0, 28'd2, 16'd20);
        run_to(10012); arm_timer(1, 28'd2, 16'd12);
        run_to(10041);
        check("R8 replaced TX target silent", 64'(task_fire), 64'd0);
        run_to(10048);
        check("R7 RX not yet", 64'(task_fire), 64'd0);
        run_to(10049);
        check("R7 RX fires", 64'(task_fire), 64'b10);
        run_to(10050);
        check("R8 RX disarmed", 64'(task_fire), 64'd0);
        run_to(10081);
        check("R7 TX fires at new target", 64'(task_fire), 64'b01);
        run_to(10082);
        check("R8 TX disarmed", 64'(task_fire), 64'd0);

        // R9 freeze at slot 2 phase 500
        run_to(12000);
        check("R3 native at freeze", 64'(native_clk), 64'd2);
        check("R2 phase at freeze", 64'(native_ph), 64'd500);
        prescale_en = 1'b1;
        repeat (50) @(negedge clk);
        check("R9 native held", 64'(native_clk), 64'd2);
        check("R9 phase held", 64'(native_ph), 64'd500);

        // R4/R5 offset table
        for (int i = 0; i < NV; i++) begin
            write_ofs(VEC[i][87:60], VEC[i][59:44]);
            check((i == 7) ? "R5 saturated phase offset" : "R4 master_clk",
                  64'(master_clk), 64'(VEC[i][43:16]));
            check((i == 7) ? "R5 saturated phase offset" : "R4 master_ph",
                  64'(master_ph), 64'(VEC[i][15:0]));
        end
        write_ofs(28'd0, 16'd0);

        // R9 external enable advances native only
        for (int j = 0; j < 3; j++) begin
            ext_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0;
            check("R9 ext_tick advance", 64'(native_clk), 64'(3 + j));
            check("R9 phase still held", 64'(native_ph), 64'd500);
            @(negedge clk);
        end

        // R7 timer fires in low-power mode
        arm_timer(0, 28'd6, 16'd500);
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
        check("R7 match cycle no fire yet", 64'(task_fire), 64'd0);
        @(negedge clk);
        check("R7 TX fires in prescale", 64'(task_fire), 64'b01);

        // R10 resume from held phase and divider
        prescale_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 phase before resume tick", 64'(native_ph), 64'd500);
        @(negedge clk);
        check("R10 phase resumes", 64'(native_ph), 64'd501);
        check("R10 native kept", 64'(native_clk), 64'd6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule